// File: doc/BRIEF.md
# Inclusive Two-Level Cache Controller

This block sequences the tag, state and word-sized data arrays of a small direct-mapped first-level cache and a larger direct-mapped second-level cache. Every block held in the first level is also held in the second level. A CPU port carries one request at a time: a valid strobe, a read/write flag, a word address and write data. The controller answers with a one-cycle done pulse and, for reads, the data. A block-level memory port behind the second level serves fetches and write-backs. It uses a request/acknowledge handshake.

Addresses are word addresses and each block is one word. The first-level index is the low `L1IW` address bits. The second-level index is the low `L2IW` address bits, with `L2IW >= L1IW`. The remaining upper bits form each level's tag. Writes go through from the first level into the second level. The second level is write-back and keeps a modified bit on each line. A write that misses the first level is not allocated there. When a second-level line is replaced, any copy of the old block in the first level is dropped.

Top module: `incl_cache_ctrl`

## Requirements
- R1: A request whose block is in the first level completes with `cpuDone` high in the cycle right after the accepting edge (latency 1), with no memory traffic. A read returns the current value of the word.
- R2: A read that misses the first level but hits the second level completes in more than one cycle with no memory traffic. It copies the block into the first level, so an immediate re-read has latency 1.
- R3: A read that misses both levels makes exactly one memory read of the requested address. It installs the block in both levels and returns the memory word.
- R4: A write updates the second-level copy and marks it modified. It also updates the first-level copy when that level holds the block, and a later read returns the written value.
- R5: A write that misses the first level is not allocated there. A write that also misses the second level claims the second-level line with no memory read.
- R6: When the second-level line to be replaced is modified, exactly one memory write of the old address and its latest value is made, and it finishes before any memory read. A clean victim is never written back.
- R7: Replacing a second-level line removes the old block from the first level. A later read of that block misses both levels (one memory read) and returns the correct value.
- R8: At every clock edge, each valid first-level line is present in the second level with equal data.
- R9: After reset both levels are empty and `cpuDone` and `memReq` are low. The first access to any address misses both levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Request strobe, sampled while the controller is idle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | AW | Word address |
| cpuWdata | input | DW | Write data |
| cpuRdata | output | DW | Read data, valid with `cpuDone` |
| cpuDone | output | 1 | One-cycle completion pulse |
| memReq | output | 1 | Memory request, held until `memAck` |
| memWe | output | 1 | 1 = write-back, 0 = fetch |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Write-back data |
| memRdata | input | DW | Fetched data, valid with `memAck` |
| memAck | input | 1 | One-cycle acknowledge from memory |

## Verification
The bench builds the block with a 6-bit address, 4 first-level lines and 8 second-level lines, with 16-bit data. Addresses 8 apart then collide in the second level, so dirty and clean evictions and back-invalidation occur within a few requests. Addresses 4 apart that differ in the second level displace each other only in the first level, which reaches the refill from the second level. A behavioural model of which address each line holds predicts the latency class, the memory reads and the write-backs of every request.

// File: rtl/incl_cache_pkg.sv
package incl_cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_WBACK, ST_FETCH, ST_REFILL, ST_FINISH
  } ctlState_t;

  // strobes from the sequencer to the array datapath
  typedef struct packed {
    logic takeReq;    // use live CPU fields and latch them
    logic access;     // perform the read or write-through on the current address
    logic refillL1;   // copy second-level line into first level
    logic fillBoth;   // install fetched word into both levels
    logic claimL2;    // take second-level line for a write miss
    logic backInval;  // drop old victim from first level
    logic clearDirty; // write-back finished
    logic selVictim;  // memory address is the victim's
  } strobes_t;

endpackage

// File: rtl/incl_cache_dp.sv
module incl_cache_dp
  import incl_cache_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int L1IW = 2,
  parameter int L2IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuDone,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          opWrite,
  output logic          l1Hit,
  output logic          l2Hit,
  output logic          victimValid,
  output logic          victimDirty
);
  localparam int L1N = 1 << L1IW;
  localparam int L2N = 1 << L2IW;
  localparam int T1W = AW - L1IW;
  localparam int T2W = AW - L2IW;

  logic [L1N-1:0] l1Valid;
  logic [T1W-1:0] l1Tag  [L1N];
  logic [DW-1:0]  l1Data [L1N];
  logic [L2N-1:0] l2Valid, l2Dirty;
  logic [T2W-1:0] l2Tag  [L2N];
  logic [DW-1:0]  l2Data [L2N];

  logic [AW-1:0] reqAddr, curAddr, victimAddr;
  logic [DW-1:0] reqData, curData, rdataQ;
  logic          reqWr, doneQ;
  logic [L1IW-1:0] i1;
  logic [L2IW-1:0] i2;
  logic [T1W-1:0]  t1;
  logic [T2W-1:0]  t2;
  logic            victimInL1;

  assign curAddr = st.takeReq ? cpuAddr  : reqAddr;
  assign curData = st.takeReq ? cpuWdata : reqData;
  assign opWrite = st.takeReq ? cpuWrite : reqWr;

  assign i1 = curAddr[L1IW-1:0];
  assign i2 = curAddr[L2IW-1:0];
  assign t1 = curAddr[AW-1:L1IW];
  assign t2 = curAddr[AW-1:L2IW];

  assign l1Hit       = l1Valid[i1] && (l1Tag[i1] == t1);
  assign l2Hit       = l2Valid[i2] && (l2Tag[i2] == t2);
  assign victimValid = l2Valid[i2];
  assign victimDirty = l2Dirty[i2];
  assign victimAddr  = {l2Tag[i2], i2};
  // victim shares the first-level slot of the current address
  assign victimInL1  = l1Valid[i1] && (l1Tag[i1] == victimAddr[AW-1:L1IW]);

  assign memAddr  = st.selVictim ? victimAddr : curAddr;
  assign memWdata = l2Data[i2];
  assign cpuRdata = rdataQ;
  assign cpuDone  = doneQ;

  // state bits and request latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      l1Valid <= '0;
      l2Valid <= '0;
      l2Dirty <= '0;
      doneQ   <= 1'b0;
      rdataQ  <= '0;
      reqAddr <= '0;
      reqData <= '0;
      reqWr   <= 1'b0;
    end else begin
      doneQ <= st.access;
      if (st.takeReq) begin
        reqAddr <= cpuAddr;
        reqData <= cpuWdata;
        reqWr   <= cpuWrite;
      end
      if (st.backInval && victimInL1) l1Valid[i1] <= 1'b0;
      if (st.clearDirty) l2Dirty[i2] <= 1'b0;
      if (st.claimL2 || st.fillBoth) begin
        l2Valid[i2] <= 1'b1;
        l2Dirty[i2] <= 1'b0;
      end
      if (st.fillBoth || st.refillL1) l1Valid[i1] <= 1'b1;
      if (st.access) begin
        if (opWrite) l2Dirty[i2] <= 1'b1;
        else         rdataQ <= l1Hit ? l1Data[i1] : l2Data[i2];
      end
    end
  end

  // tag and data arrays, no reset
  always_ff @(posedge clk) begin
    if (st.claimL2 || st.fillBoth) l2Tag[i2] <= t2;
    if (st.fillBoth) begin
      l2Data[i2] <= memRdata;
      l1Data[i1] <= memRdata;
    end
    if (st.fillBoth || st.refillL1) l1Tag[i1] <= t1;
    if (st.refillL1) l1Data[i1] <= l2Data[i2];
    if (st.access && opWrite) begin
      l2Data[i2] <= curData;
      if (l1Hit) l1Data[i1] <= curData;
    end
  end

  for (genvar g = 0; g < L1N; g++) begin : g_incl
    logic [AW-1:0]   lineAddr;
    logic [L2IW-1:0] lineIdx;
    assign lineAddr = {l1Tag[g], L1IW'(g)};
    assign lineIdx  = lineAddr[L2IW-1:0];

    // R8
    incl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      l1Valid[g] |-> (l2Valid[lineIdx] && l2Tag[lineIdx] == lineAddr[AW-1:L2IW]));

    // R8
    wt_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      l1Valid[g] |-> (l1Data[g] == l2Data[lineIdx]));
  end

endmodule

// File: rtl/incl_cache_fsm.sv
module incl_cache_fsm
  import incl_cache_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cpuValid,
  input  logic     opWrite,
  input  logic     l1Hit,
  input  logic     l2Hit,
  input  logic     victimValid,
  input  logic     victimDirty,
  input  logic     memAck,
  output strobes_t st,
  output logic     memReq,
  output logic     memWe
);
  ctlState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    st     = '0;
    nxt    = state;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (state)
      ST_IDLE: if (cpuValid) begin
        st.takeReq = 1'b1;
        if (l1Hit) st.access = 1'b1;
        else       nxt = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (l2Hit) nxt = opWrite ? ST_FINISH : ST_REFILL;
        else begin
          st.backInval = victimValid;
          if (victimValid && victimDirty) nxt = ST_WBACK;
          else if (opWrite) begin
            st.claimL2 = 1'b1;
            nxt = ST_FINISH;
          end else nxt = ST_FETCH;
        end
      end
      ST_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        st.selVictim = 1'b1;
        if (memAck) begin
          st.clearDirty = 1'b1;
          if (opWrite) begin
            st.claimL2 = 1'b1;
            nxt = ST_FINISH;
          end else nxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          st.fillBoth = 1'b1;
          nxt = ST_FINISH;
        end
      end
      ST_REFILL: begin
        st.refillL1 = 1'b1;
        nxt = ST_FINISH;
      end
      ST_FINISH: begin
        st.access = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  // R6
  fetch_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> !(victimValid && victimDirty));

  // R5
  fetch_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |-> !opWrite);

  // R1
  hit_in_l2_chk: assert property (@(posedge clk) disable iff (!rstN)
    l1Hit |-> l2Hit);

endmodule

// File: rtl/incl_cache_ctrl.sv
module incl_cache_ctrl
  import incl_cache_pkg::*;
#(
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int L1IW = 2,
  parameter int L2IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuValid,
  input  logic          cpuWrite,
  input  logic [AW-1:0] cpuAddr,
  input  logic [DW-1:0] cpuWdata,
  output logic [DW-1:0] cpuRdata,
  output logic          cpuDone,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata,
  input  logic          memAck
);
  strobes_t st;
  logic opWrite, l1Hit, l2Hit, victimValid, victimDirty;

  incl_cache_fsm u_fsm (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .opWrite(opWrite),
    .l1Hit(l1Hit), .l2Hit(l2Hit), .victimValid(victimValid),
    .victimDirty(victimDirty), .memAck(memAck), .st(st),
    .memReq(memReq), .memWe(memWe)
  );

  incl_cache_dp #(.AW(AW), .DW(DW), .L1IW(L1IW), .L2IW(L2IW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .memRdata(memRdata), .cpuRdata(cpuRdata),
    .cpuDone(cpuDone), .memAddr(memAddr), .memWdata(memWdata),
    .opWrite(opWrite), .l1Hit(l1Hit), .l2Hit(l2Hit),
    .victimValid(victimValid), .victimDirty(victimDirty)
  );

endmodule

// File: tb/tb_incl_cache_ctrl.sv
module tb_incl_cache_ctrl;
  localparam int CLK_P = 10;
  localparam int AW = 6, DW = 16, L1IW = 2, L2IW = 3;
  localparam int N1 = 1 << L1IW, N2 = 1 << L2IW, NW = 1 << AW;
  localparam int MEM_LAT = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DW-1:0] cpuWdata = '0;
  logic [DW-1:0] cpuRdata, memWdata;
  logic cpuDone, memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memRdata = '0;
  logic memAck = 1'b0;

  int checks = 0, errors = 0;
  int nReads = 0, nWrites = 0, seq = 0, rdStamp = 0, wrStamp = 0;
  int lastWrAddr = 0, lastWrData = 0;
  int bmem [NW];
  int refv [NW];
  int l1a [N1];
  int l2a [N2];
  bit l2d [N2];
  bit wasInval [NW];

  incl_cache_ctrl #(.AW(AW), .DW(DW), .L1IW(L1IW), .L2IW(L2IW)) dut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuDone(cpuDone), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // memory responder: acknowledges after MEM_LAT cycles of request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        cnt = 0;
      end else if (memReq) begin
        cnt++;
        if (cnt == MEM_LAT) begin
          memAck = 1'b1;
          seq++;
          if (memWe) begin
            bmem[memAddr] = int'(memWdata);
            nWrites++;
            wrStamp = seq;
            lastWrAddr = int'(memAddr);
            lastWrData = int'(memWdata);
          end else begin
            memRdata = DW'(bmem[memAddr]);
            nReads++;
            rdStamp = seq;
          end
        end
      end
    end
  end

  task automatic doOp(input bit w, input int a, input int d);
    int i1 = a % N1, i2 = a % N2;
    bit hit1 = (l1a[i1] == a);
    bit hit2 = (l2a[i2] == a);
    int victim = l2a[i2];
    int expRd = (!hit2 && !w) ? 1 : 0;
    int expWr = (!hit2 && victim >= 0 && l2d[i2]) ? 1 : 0;
    int expWd = (victim >= 0) ? refv[victim] : 0;
    int rd0 = nReads, wr0 = nWrites, lat = 0;
    string tag;
    if (hit1) tag = "R1";
    else if (wasInval[a]) tag = "R7";
    else if (w) tag = hit2 ? "R4" : "R5";
    else tag = hit2 ? "R2" : "R3";
    wasInval[a] = 1'b0;
    // model update
    if (!hit2) begin
      if (victim >= 0 && l1a[victim % N1] == victim) begin
        l1a[victim % N1] = -1;
        wasInval[victim] = 1'b1;
      end
      l2a[i2] = a;
      l2d[i2] = 1'b0;
    end
    if (!w) l1a[i1] = a;
    else begin
      refv[a] = d & 16'hFFFF;
      l2d[i2] = 1'b1;
    end
    // drive and wait
    cpuValid = 1'b1;
    cpuWrite = w;
    cpuAddr  = a[AW-1:0];
    cpuWdata = d[DW-1:0];
    do begin
      @(negedge clk);
      lat++;
      cpuValid = 1'b0;
    end while (!cpuDone && lat < 200);
    check(cpuDone, tag, "done seen", lat, 0);
    if (hit1) check(lat == 1, tag, "hit latency", lat, 1);
    else      check(lat > 1, tag, "miss latency above 1", lat, 2);
    check(nReads - rd0 == expRd, tag, "memory reads", nReads - rd0, expRd);
    check(nWrites - wr0 == expWr, "R6", "write-backs", nWrites - wr0, expWr);
    if (expWr == 1 && nWrites - wr0 == 1) begin
      check(lastWrAddr == victim, "R6", "write-back address", lastWrAddr, victim);
      check(lastWrData == expWd, "R6", "write-back data", lastWrData, expWd);
      if (expRd == 1) check(wrStamp < rdStamp, "R6", "write-back before fetch", wrStamp, rdStamp);
    end
    if (!w) check(int'(cpuRdata) == refv[a], tag, "read data", int'(cpuRdata), refv[a]);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lfsr = 16'hACE1;
    for (int i = 0; i < NW; i++) begin
      bmem[i] = (i * 371 + 29) & 16'hFFFF;
      refv[i] = bmem[i];
      wasInval[i] = 1'b0;
    end
    for (int i = 0; i < N1; i++) l1a[i] = -1;
    for (int i = 0; i < N2; i++) begin
      l2a[i] = -1;
      l2d[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(cpuDone == 1'b0, "R9", "done after reset", int'(cpuDone), 0);
    check(memReq == 1'b0, "R9", "memReq after reset", int'(memReq), 0);

    doOp(0, 5, 0);          // R9 first access misses both, R3
    doOp(0, 5, 0);          // R1 read hit
    doOp(1, 5, 16'hAAAA);   // R1/R4 write hit through to L2
    doOp(0, 5, 0);
    doOp(0, 13, 0);         // R6 dirty victim 5 written back first
    doOp(0, 5, 0);          // R6 clean victim 13, memory holds AAAA
    doOp(0, 1, 0);          // displaces 5 from L1 only
    doOp(0, 5, 0);          // R2 L1 miss, L2 hit
    doOp(0, 5, 0);
    doOp(1, 21, 16'h1234);  // R5 write miss claims L2, back-invalidates 5
    doOp(0, 5, 0);          // R7 and R8: 5 must miss both levels
    doOp(0, 21, 0);
    doOp(1, 2, 16'h0F0F);   // R5 no L1 allocation
    doOp(0, 2, 0);          // R2 refill from L2
    doOp(1, 10, 16'h5555);  // R6 dirty victim 2, no fetch
    doOp(0, 2, 0);
    doOp(0, 10, 0);
    for (int k = 0; k < 120; k++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      doOp(lfsr[9] & lfsr[3], lfsr % 24, lfsr ^ k);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule